// File: doc/BRIEF.md
# Dual-Slot Card Power Switch Controller

This block is the digital control for a two-slot card power switch. A host controller sends a 9-bit control word over three wires: a data line, a shift clock and a latch strobe. Bits are shifted in on rising edges of the shift clock. A rising edge of the strobe copies the shifted word into a holding register. The held word selects, for each of the four card supply outputs (VCC and VPP of slot A and of slot B), which of three power switches is closed, or that none is.

Enables change only through an open interval. When an output moves to a different source, its old switch opens first. The new switch closes only after a dead time counted in system-clock cycles. A thermal-fault input opens every switch while it is active. Four per-output overcurrent flags are merged into one active-low fault line. The three serial wires are asynchronous to the system clock. They are synchronized, and their edges are detected in the system-clock domain.

Top module: `pwrsw_ctrl`

## Requirements
- R1: After reset the holding register is all zeros, so every enable is 0 and `oc_n` is 1.
- R2: Control bits enter on rising `ser_clk` edges, with bit 8 sent first and bit 0 sent last. A rising `ser_latch` edge applies the word. Shifting a word without a latch strobe leaves the outputs unchanged.
- R3: Bit 8 is an active-low shutdown. When it is 0, all twelve enables are 0 whatever the other bits hold.
- R4: Every enable vector has three bits: bit 0 is the ground switch, bit 1 is the low source and bit 2 is the high source. At most one bit of a vector is set.
- R5: Slot A VPP takes the code {bit0,bit1}: 00 gives ground (001), 01 gives slot VCC (010), 10 gives 12 V (100) and 11 opens all switches (000).
- R6: Slot B VPP uses the same mapping as R5, with the code {bit4,bit5}.
- R7: Slot A VCC takes the code {bit3,bit2}: 00 gives ground (001), 01 gives 3.3 V (010), 10 gives 5 V (100) and 11 gives ground (001).
- R8: Slot B VCC uses the same mapping as R7, with the code {bit6,bit7}.
- R9: An output never changes directly from one closed switch to another. Between them it stays fully open for exactly DEAD_CYC system-clock cycles (default 4).
- R10: `oc_n` is 0 while any bit of `oc_flag` is 1, and 1 otherwise.
- R11: Overcurrent flags have no effect on any enable.
- R12: While `thermal_flt` is 1, every enable is 0 from the next clock on. After it clears, the held word is applied again without a new serial transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_data | input | 1 | Serial control data |
| ser_clk | input | 1 | Serial shift clock, rising edge samples data |
| ser_latch | input | 1 | Rising edge transfers the shifted word |
| thermal_flt | input | 1 | Thermal fault, active high, synchronous to clk |
| oc_flag | input | 4 | Overcurrent flags: [0] A VCC, [1] A VPP, [2] B VCC, [3] B VPP |
| oc_n | output | 1 | Combined overcurrent, active low |
| a_vcc_en | output | 3 | Slot A VCC switches {5 V, 3.3 V, ground} |
| a_vpp_en | output | 3 | Slot A VPP switches {12 V, VCC, ground} |
| b_vcc_en | output | 3 | Slot B VCC switches {5 V, 3.3 V, ground} |
| b_vpp_en | output | 3 | Slot B VPP switches {12 V, VCC, ground} |

## Verification
All four codes of each output field are applied, one output at a time, while the other fields hold differing values. A swapped field, a reversed bit pair or a wrong 11 mapping therefore shows up on one output only. Words with the shutdown bit cleared but every other field active separate the shutdown gating from plain decoding. A 3.3 V to 5 V step is timed cycle by cycle to pin down the dead time. A background monitor flags any direct move between two closed switches. Overcurrent and thermal patterns are applied over a live word to show that the first only reports and the second overrides and then restores.

// File: rtl/pwrsw_pkg.sv
// Shared types for the card power switch controller.
// Assumes the 9-bit word layout fixed by the slot decoders.
package pwrsw_pkg;
    localparam int WORD_W  = 9;
    localparam int NUM_OUT = 4;
    localparam int NUM_SRC = 3;

    // Source choice for one output; SRC_OPEN leaves all switches open.
    typedef enum logic [1:0] {
        SRC_GND  = 2'd0,
        SRC_LO   = 2'd1,
        SRC_HI   = 2'd2,
        SRC_OPEN = 2'd3
    } src_sel_t;
endpackage

// File: rtl/pwrsw_serial_rx.sv
// Serial receiver: synchronizes the three wires, shifts data on rising
// shift-clock edges, and copies the word on a rising latch edge.
// Assumes the wires change slowly compared with clk.
module pwrsw_serial_rx #(
    parameter int WORD_W      = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_data,
    input  logic              ser_clk,
    input  logic              ser_latch,
    output logic [WORD_W-1:0] hold_word
);
    logic [SYNC_STAGES-1:0] data_s, clk_s, lat_s;
    logic                   clk_q, lat_q;
    logic [WORD_W-1:0]      shift_q;
    logic                   clk_rise, lat_rise;

    // Synchronizer chains and previous-value flops for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_s <= '0;
            clk_s  <= '0;
            lat_s  <= '0;
            clk_q  <= 1'b0;
            lat_q  <= 1'b0;
        end else begin
            data_s <= {data_s[SYNC_STAGES-2:0], ser_data};
            clk_s  <= {clk_s[SYNC_STAGES-2:0], ser_clk};
            lat_s  <= {lat_s[SYNC_STAGES-2:0], ser_latch};
            clk_q  <= clk_s[SYNC_STAGES-1];
            lat_q  <= lat_s[SYNC_STAGES-1];
        end
    end

    // Rising edges in the system-clock domain.
    always_comb begin
        clk_rise = clk_s[SYNC_STAGES-1] & ~clk_q;
        lat_rise = lat_s[SYNC_STAGES-1] & ~lat_q;
    end

    // Shift towards the MSB so the first bit sent ends up in the top bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shift_q <= '0;
        else if (clk_rise)
            shift_q <= {shift_q[WORD_W-2:0], data_s[SYNC_STAGES-1]};
    end

    // Holding register, cleared at reset so the block starts in shutdown.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_word <= '0;
        else if (lat_rise)
            hold_word <= shift_q;
    end
endmodule

// File: rtl/pwrsw_decode.sv
// Decodes the held word into a source choice for each of the four
// outputs. Order: 0 A VCC, 1 A VPP, 2 B VCC, 3 B VPP.
module pwrsw_decode
    import pwrsw_pkg::*;
(
    input  logic [WORD_W-1:0]         word,
    output src_sel_t [NUM_OUT-1:0]    tgt
);
    // VCC fields: code 3 selects ground like code 0.
    function automatic src_sel_t vcc_map(input logic [1:0] code);
        return (code == 2'b11) ? SRC_GND : src_sel_t'(code);
    endfunction

    // VPP fields map straight onto the source encoding.
    function automatic src_sel_t vpp_map(input logic [1:0] code);
        return src_sel_t'(code);
    endfunction

    // Field extraction with shutdown gating on bit 8.
    always_comb begin
        if (!word[8]) begin
            tgt = {NUM_OUT{SRC_OPEN}};
        end else begin
            tgt[0] = vcc_map({word[3], word[2]});
            tgt[1] = vpp_map({word[0], word[1]});
            tgt[2] = vcc_map({word[6], word[7]});
            tgt[3] = vpp_map({word[4], word[5]});
        end
    end
endmodule

// File: rtl/pwrsw_bbm.sv
// Break-before-make sequencer for one output. Opens the present switch,
// waits DEAD_CYC cycles fully open, then closes the requested one.
// A forced open takes effect on the next clock.
module pwrsw_bbm
    import pwrsw_pkg::*;
#(
    parameter int DEAD_CYC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               force_open,
    input  src_sel_t           tgt,
    output logic [NUM_SRC-1:0] en
);
    localparam int CW = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(DEAD_CYC - 1);

    src_sel_t      applied, want;
    logic [CW-1:0] cnt;

    // Thermal override takes priority over the decoded target.
    always_comb want = force_open ? SRC_OPEN : tgt;

    // Sequencer: break at once, make after the dead-time count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            applied <= SRC_OPEN;
            cnt     <= '0;
        end else if (want == applied) begin
            cnt <= '0;
        end else if (applied != SRC_OPEN) begin
            applied <= SRC_OPEN;
            cnt     <= '0;
        end else if (cnt == LAST) begin
            applied <= want;
            cnt     <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // One-hot switch enables from the applied source.
    always_comb begin
        case (applied)
            SRC_GND: en = 3'b001;
            SRC_LO:  en = 3'b010;
            SRC_HI:  en = 3'b100;
            default: en = 3'b000;
        endcase
    end
endmodule

// File: rtl/pwrsw_ctrl.sv
// Top of the dual-slot power switch controller: serial receiver,
// word decoder, one sequencer per output, and overcurrent merge.
// Assumes thermal_flt and oc_flag are synchronous to clk.
module pwrsw_ctrl
    import pwrsw_pkg::*;
#(
    parameter int DEAD_CYC    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_data,
    input  logic               ser_clk,
    input  logic               ser_latch,
    input  logic               thermal_flt,
    input  logic [NUM_OUT-1:0] oc_flag,
    output logic               oc_n,
    output logic [NUM_SRC-1:0] a_vcc_en,
    output logic [NUM_SRC-1:0] a_vpp_en,
    output logic [NUM_SRC-1:0] b_vcc_en,
    output logic [NUM_SRC-1:0] b_vpp_en
);
    logic [WORD_W-1:0]                hold_word;
    src_sel_t [NUM_OUT-1:0]           tgt;
    logic [NUM_OUT-1:0][NUM_SRC-1:0]  sw_en;

    pwrsw_serial_rx #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
        .ser_latch(ser_latch), .hold_word(hold_word)
    );

    pwrsw_decode u_dec (.word(hold_word), .tgt(tgt));

    // One sequencer per supply output.
    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
        pwrsw_bbm #(.DEAD_CYC(DEAD_CYC)) u_bbm (
            .clk(clk), .rst_n(rst_n), .force_open(thermal_flt),
            .tgt(tgt[g]), .en(sw_en[g])
        );
    end

    // Output mapping and the merged active-low overcurrent line.
    always_comb begin
        a_vcc_en = sw_en[0];
        a_vpp_en = sw_en[1];
        b_vcc_en = sw_en[2];
        b_vpp_en = sw_en[3];
        oc_n     = ~(|oc_flag);
    end
endmodule

// File: rtl/pwrsw_ctrl_chk.sv
// Property checker for pwrsw_ctrl, attached through bind.
module pwrsw_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       thermal_flt,
    input logic [8:0] hold_word,
    input logic [2:0] a_vcc_en,
    input logic [2:0] a_vpp_en,
    input logic [2:0] b_vcc_en,
    input logic [2:0] b_vpp_en
);
    logic [3:0][2:0] en;
    always_comb en = {b_vpp_en, b_vcc_en, a_vpp_en, a_vcc_en};

    for (genvar g = 0; g < 4; g++) begin : g_chk
        // R4
        onehot_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(en[g]));
        // R9
        no_direct_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((en[g] != 3'b000) && ($past(en[g]) != 3'b000)) |-> (en[g] == $past(en[g])));
    end

    // R12
    thermal_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thermal_flt |=> (en == '0));

    // R3
    shutdown_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_word[8]) |=> (en == '0));
endmodule

bind pwrsw_ctrl pwrsw_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .thermal_flt(thermal_flt),
    .hold_word(hold_word), .a_vcc_en(a_vcc_en), .a_vpp_en(a_vpp_en),
    .b_vcc_en(b_vcc_en), .b_vpp_en(b_vpp_en)
);

// File: tb/pwrsw_ctrl_test.sv
// Directed bench for pwrsw_ctrl.
module pwrsw_ctrl_test;
    localparam int DEAD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_data = 1'b0, ser_clk = 1'b0, ser_latch = 1'b0;
    logic       thermal_flt = 1'b0;
    logic [3:0] oc_flag = 4'b0;
    logic       oc_n;
    logic [2:0] a_vcc_en, a_vpp_en, b_vcc_en, b_vpp_en;

    int checks = 0;
    int fails  = 0;

    pwrsw_ctrl #(.DEAD_CYC(DEAD)) uut (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
        .ser_latch(ser_latch), .thermal_flt(thermal_flt), .oc_flag(oc_flag),
        .oc_n(oc_n), .a_vcc_en(a_vcc_en), .a_vpp_en(a_vpp_en),
        .b_vcc_en(b_vcc_en), .b_vpp_en(b_vpp_en)
    );

    always #2.5 clk = ~clk;

    function automatic logic [11:0] all_en();
        return {b_vpp_en, b_vcc_en, a_vpp_en, a_vcc_en};
    endfunction

    // Word from field codes: VPP codes {D0,D1}/{D4,D5}, VCC {D3,D2}/{D6,D7}.
    function automatic logic [8:0] mk(input logic sd, input logic [1:0] avcc,
        input logic [1:0] avpp, input logic [1:0] bvcc, input logic [1:0] bvpp);
        logic [8:0] w;
        w[8] = sd;
        w[0] = avpp[1]; w[1] = avpp[0];
        w[3] = avcc[1]; w[2] = avcc[0];
        w[4] = bvpp[1]; w[5] = bvpp[0];
        w[6] = bvcc[1]; w[7] = bvcc[0];
        return w;
    endfunction

    function automatic logic [2:0] vpp_exp(input logic [1:0] c);
        case (c)
            2'b00: return 3'b001;
            2'b01: return 3'b010;
            2'b10: return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

    function automatic logic [2:0] vcc_exp(input logic [1:0] c);
        case (c)
            2'b01: return 3'b010;
            2'b10: return 3'b100;
            default: return 3'b001;
        endcase
    endfunction

    function automatic logic [11:0] exp_word(input logic [8:0] w);
        if (!w[8]) return 12'b0;
        return {vpp_exp({w[4], w[5]}), vcc_exp({w[6], w[7]}),
                vpp_exp({w[0], w[1]}), vcc_exp({w[3], w[2]})};
    endfunction

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_word(input logic [8:0] w);
        for (int i = 8; i >= 0; i--) begin
            ser_data = w[i];
            cyc(3); ser_clk = 1'b1;
            cyc(3); ser_clk = 1'b0;
            cyc(1);
        end
    endtask

    task automatic strobe();
        ser_latch = 1'b1; cyc(3); ser_latch = 1'b0;
    endtask

    task automatic send(input logic [8:0] w);
        shift_word(w); strobe(); cyc(25);
    endtask

    // Background break-before-make monitor on every output.
    logic [11:0] prev_en = 12'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            for (int g = 0; g < 4; g++) begin
                if (all_en()[g*3 +: 3] != 3'b0 && prev_en[g*3 +: 3] != 3'b0 &&
                    all_en()[g*3 +: 3] != prev_en[g*3 +: 3]) begin
                    fails++;
                    $display("FAIL R9: output %0d swapped %b -> %b with no open gap",
                             g, prev_en[g*3 +: 3], all_en()[g*3 +: 3]);
                end
            end
        end
        prev_en <= all_en();
    end

    task automatic t_reset();
        check("R1 enables after reset", all_en(), 12'b0);
        check("R1 oc_n after reset", {11'b0, oc_n}, 12'd1);
    endtask

    task automatic t_order_latch();
        logic [8:0] w;
        w = mk(1'b1, 2'b10, 2'b01, 2'b01, 2'b10);
        send(w);
        check("R2 word applied after latch", all_en(), exp_word(w));
        shift_word(mk(1'b1, 2'b01, 2'b10, 2'b10, 2'b00));
        cyc(25);
        check("R2 shift without latch ignored", all_en(), exp_word(w));
        strobe(); cyc(25);
        check("R2 pending word applied on latch", all_en(),
              exp_word(mk(1'b1, 2'b01, 2'b10, 2'b10, 2'b00)));
    endtask

    task automatic t_shutdown();
        send(mk(1'b0, 2'b10, 2'b10, 2'b01, 2'b01));
        check("R3 shutdown bit clear opens all", all_en(), 12'b0);
        send(mk(1'b1, 2'b10, 2'b10, 2'b01, 2'b01));
        check("R3 shutdown bit set re-enables", all_en(),
              exp_word(mk(1'b1, 2'b10, 2'b10, 2'b01, 2'b01)));
    endtask

    task automatic t_fields();
        for (int c = 0; c < 4; c++) begin
            logic [8:0] w;
            w = mk(1'b1, 2'b10, 2'(c), 2'b01, 2'b00);
            send(w);
            check($sformatf("R5 A VPP code %0d", c), {9'b0, a_vpp_en}, {9'b0, vpp_exp(2'(c))});
            check("R4 R5 other outputs", all_en(), exp_word(w));
            w = mk(1'b1, 2'b01, 2'b11, 2'b10, 2'(c));
            send(w);
            check($sformatf("R6 B VPP code %0d", c), {9'b0, b_vpp_en}, {9'b0, vpp_exp(2'(c))});
            w = mk(1'b1, 2'(c), 2'b11, 2'b10, 2'b11);
            send(w);
            check($sformatf("R7 A VCC code %0d", c), {9'b0, a_vcc_en}, {9'b0, vcc_exp(2'(c))});
            w = mk(1'b1, 2'b10, 2'b11, 2'(c), 2'b11);
            send(w);
            check($sformatf("R8 B VCC code %0d", c), {9'b0, b_vcc_en}, {9'b0, vcc_exp(2'(c))});
        end
    endtask

    task automatic t_deadtime();
        int gap;
        bit done;
        send(mk(1'b1, 2'b01, 2'b11, 2'b00, 2'b11));
        shift_word(mk(1'b1, 2'b10, 2'b11, 2'b00, 2'b11));
        ser_latch = 1'b1;
        gap = 0; done = 0;
        for (int i = 0; i < 40 && !done; i++) begin
            cyc(1);
            if (i == 3) ser_latch = 1'b0;
            if (a_vcc_en == 3'b000) gap++;
            else if (a_vcc_en == 3'b100) done = 1;
        end
        check("R9 open gap length", 12'(gap), 12'(DEAD));
        check("R9 new source reached", {9'b0, a_vcc_en}, 12'b100);
    endtask

    task automatic t_overcurrent();
        logic [8:0] w;
        w = mk(1'b1, 2'b10, 2'b10, 2'b01, 2'b01);
        send(w);
        for (int k = 0; k < 4; k++) begin
            oc_flag = 4'(1 << k);
            cyc(2);
            check($sformatf("R10 oc_n with flag %0d", k), {11'b0, oc_n}, 12'd0);
            check("R11 enables unaffected by overcurrent", all_en(), exp_word(w));
        end
        oc_flag = 4'b1111; cyc(5);
        check("R10 oc_n with all flags", {11'b0, oc_n}, 12'd0);
        check("R11 enables unaffected by all flags", all_en(), exp_word(w));
        oc_flag = 4'b0; cyc(1);
        check("R10 oc_n cleared", {11'b0, oc_n}, 12'd1);
    endtask

    task automatic t_thermal();
        logic [8:0] w;
        w = mk(1'b1, 2'b01, 2'b10, 2'b10, 2'b00);
        send(w);
        thermal_flt = 1'b1; cyc(1);
        check("R12 open one clock after fault", all_en(), 12'b0);
        cyc(15);
        check("R12 stays open during fault", all_en(), 12'b0);
        thermal_flt = 1'b0; cyc(DEAD + 3);
        check("R12 held word restored", all_en(), exp_word(w));
    endtask

    initial begin
        cyc(3);
        t_reset();
        rst_n = 1'b1;
        cyc(3);
        t_reset();
        t_order_latch();
        t_shutdown();
        t_fields();
        t_deadtime();
        t_overcurrent();
        t_thermal();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #900000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule